// File: doc/BRIEF.md
# Write-Only Clock Generator Configuration Slave

This block is a two-wire serial slave that only accepts writes. It holds the control registers of a clock generator. SCL and SDA are oversampled by the system clock through two-flop synchronizers. Start and stop conditions are found from edges of the sampled lines. The slave answers a single fixed write address. It then acknowledges and throws away two header bytes, a command code and a byte count. After the header, each data byte is stored in the next control register, always starting from the first one.

The slave has no sub-address. To change one register, the master must resend every register that comes before it. The register fields drive these outputs: the frequency select code, the software-select flag, the two-bit operating mode, the CPU and PCI clock enables, the APIC clock enable and the reference drive strength. The slave acknowledges by pulling SDA low through `sda_oe_o`. The system clock must run at least 8 times the SCL rate.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset: freq_sel_o=0, sw_freq_sel_o=0, mode_o=00, cpu_en_o=11, pci_free_en_o=1, pci_en_o=111111, apic_en_o=1, ref_drive_o=01, sda_oe_o=0.
- R2: The slave acknowledges the address byte 0xD2 (7-bit address 0x69, R/W bit 0), sent MSB first, by holding SDA low for the whole high phase of the ninth SCL pulse. sda_oe_o only rises while SCL is low.
- R3: These address bytes get no acknowledge: any other address, and 0xD3 (R/W=1). After such a byte the slave neither drives SDA nor changes a register until the next start condition.
- R4: The two bytes after the address, command code and byte count, are acknowledged. Their values affect no output.
- R5: Data bytes fill registers in a fixed order: the first to the frequency register, the second to the CPU register, the third to the PCI register, the fourth to the reference register. Each data byte is acknowledged, and outputs change only after a register write.
- R6: Frequency register: bit 6 drives freq_sel_o[0], bit 5 drives freq_sel_o[1], bit 4 drives freq_sel_o[2], bit 3 drives sw_freq_sel_o, and bits 1:0 drive mode_o (00 spread off, 01 test, 10 spread on, 11 outputs off). Bits 7 and 2 are ignored.
- R7: PCI register: bit 7 drives pci_free_en_o. Bits 3:0 drive pci_en_o[3:0], bit 5 drives pci_en_o[4] and bit 6 drives pci_en_o[5]. Bit 4 is ignored. A 1 enables the clock.
- R8: CPU register bits 1:0 drive cpu_en_o[1:0]. Reference register bit 5 drives apic_en_o and bits 1:0 drive ref_drive_o (00 low, 01 normal, 10 high). All other bits of these two registers are ignored.
- R9: Data bytes beyond the fourth are acknowledged and discarded.
- R10: A stop ends the transfer. Registers already written keep their new values, later registers keep their old ones, and a byte cut off by a stop before its eighth bit writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (oversampling) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| freq_sel_o | output | 3 | Frequency select code |
| sw_freq_sel_o | output | 1 | 1 selects the register code over the pins |
| mode_o | output | 2 | Operating mode |
| cpu_en_o | output | 2 | CPU clock enables |
| pci_free_en_o | output | 1 | Free-running PCI clock enable |
| pci_en_o | output | 6 | PCI clocks 1..6 enables |
| apic_en_o | output | 1 | APIC clock enable |
| ref_drive_o | output | 2 | Reference output drive strength |

## Verification
The main sweep sends full four-register writes with arithmetically generated bytes, together with all-zero and all-one patterns. Each field is compared with a value the bench computes on its own from the bit positions. This separates field swaps, dropped ignored-bit masking and wrong register order. Transfers with two data bytes and with six data bytes show the effect of a short transfer and of surplus bytes. A stop in the middle of a byte shows that an incomplete byte writes nothing. Wrong addresses and the read address, each followed by data that would otherwise be stored, show that the slave gives no acknowledge and changes no register after a mismatch.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;
  localparam int HDR_BYTES = 3;  // address, command, count
  localparam int REG_FREQ  = 0;
  localparam int REG_CPU   = 1;
  localparam int REG_PCI   = 2;
  localparam int REG_REF   = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_ACK, ST_IGNORE} eng_state_e;

  function automatic logic [7:0] reg_rst(int idx);
    case (idx)
      REG_FREQ: return 8'h00;
      REG_CPU:  return 8'h03;
      REG_PCI:  return 8'hEF;
      REG_REF:  return 8'h21;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_mask(int idx);
    case (idx)
      REG_FREQ: return 8'h7B;
      REG_CPU:  return 8'h03;
      REG_PCI:  return 8'hEF;
      REG_REF:  return 8'h23;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s      = scl_sync[SYNC_STAGES-1];
  assign sda_s      = sda_sync[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/byte_engine.sv
module byte_engine
  import cfg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 4,
  localparam int IDX_MAX = HDR_BYTES + NUM_REGS,
  localparam int IDX_W   = $clog2(IDX_MAX + 1),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output eng_state_e       state_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  eng_state_e       state_q;
  logic [2:0]       bit_cnt_q;
  logic [IDX_W-1:0] byte_idx_q;
  logic [6:0]       shreg_q;
  logic             sda_oe_q;
  logic             wr_en_q;
  logic [REG_W-1:0] wr_idx_q;
  logic [7:0]       wr_data_q;

  logic [7:0] rx_byte;
  logic       is_data;
  logic       addr_ok;
  assign rx_byte = {shreg_q, sda_i};
  assign is_data = (byte_idx_q >= IDX_W'(HDR_BYTES)) && (byte_idx_q < IDX_W'(IDX_MAX));
  assign addr_ok = (rx_byte == {DEV_ADDR, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
      sda_oe_q   <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_idx_q   <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q    <= ST_DATA;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        sda_oe_q   <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (state_q)
          ST_DATA: if (scl_rise_i) begin
            shreg_q   <= rx_byte[6:0];
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              if (byte_idx_q == '0 && !addr_ok) state_q <= ST_IGNORE;
              else                               state_q <= ST_ACK;
              if (is_data) begin
                wr_en_q   <= 1'b1;
                wr_idx_q  <= REG_W'(byte_idx_q - IDX_W'(HDR_BYTES));
                wr_data_q <= rx_byte;
              end
            end
          end
          ST_ACK: if (scl_fall_i) begin
            if (!sda_oe_q) begin
              sda_oe_q <= 1'b1;  // fall after bit 8: drive ack
            end else begin
              sda_oe_q  <= 1'b0;  // fall after ninth pulse
              state_q   <= ST_DATA;
              bit_cnt_q <= '0;
              if (byte_idx_q != IDX_W'(IDX_MAX)) byte_idx_q <= byte_idx_q + IDX_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign state_o   = state_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_slave_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [REG_W-1:0]          wr_idx_i,
  input  logic [7:0]                wr_data_i,
  output logic [NUM_REGS-1:0][7:0]  regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= reg_rst(i);
      else if (wr_en_i && wr_idx_i == REG_W'(i))   q <= wr_data_i & reg_mask(i);
    end
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
  import cfg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 4,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [2:0] freq_sel_o,
  output logic       sw_freq_sel_o,
  output logic [1:0] mode_o,
  output logic [1:0] cpu_en_o,
  output logic       pci_free_en_o,
  output logic [5:0] pci_en_o,
  output logic       apic_en_o,
  output logic [1:0] ref_drive_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  eng_state_e eng_state;
  logic wr_en;
  logic [REG_W-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [NUM_REGS-1:0][7:0] regs;

  bus_sampler #(.SYNC_STAGES(2)) u_smp (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  byte_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_oe_o, .state_o(eng_state),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  cfg_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .regs_o(regs)
  );

  assign freq_sel_o    = {regs[REG_FREQ][4], regs[REG_FREQ][5], regs[REG_FREQ][6]};
  assign sw_freq_sel_o = regs[REG_FREQ][3];
  assign mode_o        = regs[REG_FREQ][1:0];
  assign cpu_en_o      = regs[REG_CPU][1:0];
  assign pci_free_en_o = regs[REG_PCI][7];
  assign pci_en_o      = {regs[REG_PCI][6], regs[REG_PCI][5], regs[REG_PCI][3:0]};
  assign apic_en_o     = regs[REG_REF][5];
  assign ref_drive_o   = regs[REG_REF][1:0];
endmodule

// File: rtl/cfg_slave_chk.sv
module cfg_slave_chk
  import cfg_slave_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input eng_state_e state_i,
  input logic       wr_en_i,
  input logic [2:0] freq_sel_o,
  input logic [1:0] mode_o,
  input logic [1:0] cpu_en_o,
  input logic [5:0] pci_en_o,
  input logic [1:0] ref_drive_o
);
  logic [12:0] outs;
  assign outs = {freq_sel_o, mode_o, cpu_en_o, pci_en_o};

  p_ack_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  p_no_drive_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IGNORE) |-> !sda_oe_o);
  p_no_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IGNORE) |-> !wr_en_i);
  p_outs_change_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(outs) |-> $past(wr_en_i));
  p_ref_change_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_drive_o) |-> $past(wr_en_i));
  p_idle_no_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_o);
endmodule

bind clkgen_cfg_slave cfg_slave_chk u_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o,
  .state_i(eng_state), .wr_en_i(wr_en),
  .freq_sel_o, .mode_o, .cpu_en_o, .pci_en_o, .ref_drive_o
);

// File: tb/clkgen_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module clkgen_cfg_slave_tb_top;
  localparam int H = 10;  // sys clocks per SCL half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [2:0] freq_sel;
  logic sw_sel, pci_free, apic;
  logic [1:0] mode, cpu_en, ref_drv;
  logic [5:0] pci_en;

  int checks = 0, errors = 0;
  logic [7:0] m [4];
  logic [7:0] tx [8];
  logic [7:0] msk [4];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clkgen_cfg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .freq_sel_o(freq_sel), .sw_freq_sel_o(sw_sel),
    .mode_o(mode), .cpu_en_o(cpu_en), .pci_free_en_o(pci_free),
    .pci_en_o(pci_en), .apic_en_o(apic), .ref_drive_o(ref_drv)
  );

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    logic [2:0] e_fs;
    logic [5:0] e_pci;
    e_fs  = {m[0][4], m[0][5], m[0][6]};
    e_pci = {m[2][6], m[2][5], m[2][3:0]};
    chk(freq_sel == e_fs, req, "freq_sel", int'(freq_sel), int'(e_fs));
    chk(sw_sel == m[0][3], req, "sw_sel", int'(sw_sel), int'(m[0][3]));
    chk(mode == m[0][1:0], req, "mode", int'(mode), int'(m[0][1:0]));
    chk(cpu_en == m[1][1:0], req, "cpu_en", int'(cpu_en), int'(m[1][1:0]));
    chk(pci_free == m[2][7], req, "pci_free", int'(pci_free), int'(m[2][7]));
    chk(pci_en == e_pci, req, "pci_en", int'(pci_en), int'(e_pci));
    chk(apic == m[3][5], req, "apic", int'(apic), int'(m[3][5]));
    chk(ref_drv == m[3][1:0], req, "ref_drive", int'(ref_drv), int'(m[3][1:0]));
  endtask

  task automatic bit_out(input logic b);
    wc(H/2); sda_m = b; wc(H/2); scl_m = 1'b1; wc(H); scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    wc(H/2); sda_m = 1'b1; wc(H/2); scl_m = 1'b1; wc(H); sda_m = 1'b0; wc(H); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    wc(H/2); sda_m = 1'b0; wc(H/2); scl_m = 1'b1; wc(H); sda_m = 1'b1; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    wc(H/2); sda_m = 1'b1; wc(H/2); scl_m = 1'b1;
    wc(1); acked = !sda_line;
    wc(H-2); acked = acked & !sda_line;
    wc(1); scl_m = 1'b0;
  endtask

  // full transfer: address, command, count, n data bytes from tx[]
  task automatic xfer(input logic [7:0] addr, input int n, input bit exp_ack, input string req);
    logic a;
    i2c_start();
    send_byte(addr, a);
    chk(a == exp_ack, exp_ack ? "R2" : "R3", "address ack", int'(a), int'(exp_ack));
    send_byte(8'h5C, a);
    chk(a == exp_ack, exp_ack ? "R4" : "R3", "command ack", int'(a), int'(exp_ack));
    send_byte(8'hA7, a);
    chk(a == exp_ack, exp_ack ? "R4" : "R3", "count ack", int'(a), int'(exp_ack));
    for (int j = 0; j < n; j++) begin
      send_byte(tx[j], a);
      chk(a == exp_ack, (j >= 4) ? "R9" : (exp_ack ? "R5" : "R3"), "data ack", int'(a), int'(exp_ack));
      if (exp_ack && j < 4) m[j] = tx[j] & msk[j];
    end
    i2c_stop();
    wc(8);
    check_outs(req);
  endtask

  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    msk[0] = 8'h7B; msk[1] = 8'h03; msk[2] = 8'hEF; msk[3] = 8'h21 | 8'h02;
    m[0] = 8'h00; m[1] = 8'h03; m[2] = 8'hEF; m[3] = 8'h21;
    wc(5); rst_n = 1'b1; wc(5);
    // R1 reset state
    check_outs("R1");
    chk(sda_oe == 1'b0, "R1", "sda_oe", int'(sda_oe), 0);

    // R5 R6 R7 R8 extreme patterns
    for (int j = 0; j < 4; j++) tx[j] = 8'h00;
    xfer(8'hD2, 4, 1'b1, "R6");
    for (int j = 0; j < 4; j++) tx[j] = 8'hFF;
    xfer(8'hD2, 4, 1'b1, "R7");
    // arithmetic sweep, each register gets a distinct byte
    for (int k = 0; k < 24; k++) begin
      for (int j = 0; j < 4; j++) tx[j] = 8'((k * 53 + j * 29 + 7) ^ (k << 3));
      xfer(8'hD2, 4, 1'b1, "R8");
    end
    // single-bit walk in every register to pin field positions
    for (int b = 0; b < 8; b++) begin
      for (int j = 0; j < 4; j++) tx[j] = 8'(1 << ((b + j) % 8));
      xfer(8'hD2, 4, 1'b1, "R5");
    end

    // R3 wrong address and read bit: nack, nothing stored
    for (int j = 0; j < 4; j++) tx[j] = 8'h5A ^ 8'(j * 17);
    xfer(8'hD0, 4, 1'b0, "R3");
    xfer(8'hD4, 4, 1'b0, "R3");
    xfer(8'h52, 4, 1'b0, "R3");
    xfer(8'hD3, 4, 1'b0, "R3");

    // R10 short transfer: only first two registers change
    for (int j = 0; j < 4; j++) tx[j] = 8'hC3 ^ 8'(j * 0);
    xfer(8'hD2, 4, 1'b1, "R5");
    tx[0] = 8'h2C; tx[1] = 8'h01;
    xfer(8'hD2, 2, 1'b1, "R10");

    // R9 surplus bytes acked, discarded
    tx[0] = 8'h18; tx[1] = 8'h02; tx[2] = 8'h61; tx[3] = 8'h20;
    tx[4] = 8'hFF; tx[5] = 8'h00;
    xfer(8'hD2, 6, 1'b1, "R9");

    // R10 stop after 4 bits of the first data byte: no write
    i2c_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    i2c_stop();
    wc(8);
    check_outs("R10");
    chk(sda_oe == 1'b0, "R10", "sda_oe after stop", int'(sda_oe), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule